// File: doc/BRIEF.md
# Exception Classifier and Frame Selector

This block takes one detected exception event per transaction and works out everything a dispatch stage needs to enter the handler. The event arrives as a cause code, along with the address of the current instruction, the address of the next sequential instruction, a branch-taken flag with its target, four processor status bits (overflow, emulate, monitor coprocessor, task switched) and a side-information word. The side-information word carries a selector or a fault detail. The block turns these into an 8-bit vector, a class (fault, trap or abort), the return address to save, an error-code-present flag and the error code value.

The result is registered and offered with a valid/ready handshake. A new event is taken only while the output register is empty. Some causes are conditional on the status bits. When the condition is not met, the block takes the event and raises no result. Stack pushes, descriptor lookup and privilege checks happen downstream.

Top module: `exc_classifier`

## Requirements
- R1: After reset `outValid` is 0 and `inReady` is 1.
- R2: `inReady` equals the inverse of `outValid`. An event with `inValid`=1 and `inReady`=1 at a rising edge is taken at that edge. If it yields a result, `outValid` is 1 after that edge. The result holds unchanged while `outReady` is 0 and is released at the first edge where `outReady` is 1.
- R3: For a fault (class code 0), `outRetAddr` equals the `curAddr` presented with the event.
- R4: For a trap (class code 1), `outRetAddr` equals `branchTarget` when `branchTaken` is 1 and `nextAddr` otherwise.
- R5: For an abort (class code 2), `outRetAddr` is 0.
- R6: The cause codes map to a vector and a class as follows:
  - 0 gives vector 0, fault.
  - 1 gives vector 1, fault.
  - 2 gives vector 1, trap.
  - 3 gives vector 3, trap.
  - 4 gives vector 4, trap.
  - 5 gives vector 5, fault.
  - 6 gives vector 6, fault.
  - 7 (escape opcode) gives vector 7, fault.
  - 8 (wait opcode) gives vector 7, fault.
  - 9 gives vector 8, abort.
  - 10 gives vector 9, abort.
  - 11 to 15 give vectors 10 to 14, fault.
  - 16 gives vector 16, fault.
- R7: Cause 4 (overflow check) gives a result only when `ofFlag` is 1. Otherwise it is taken and dropped.
- R8: Cause 7 gives a result when `emFlag` is 1, or when both `mpFlag` and `tsFlag` are 1. Cause 8 gives a result only when both `mpFlag` and `tsFlag` are 1. Otherwise these causes are taken and dropped.
- R9: Vectors 8, 10, 11, 12, 13 and 14 set `outErrPush`. For vector 8 `outErrCode` is 0. For the others `outErrCode` equals `errInfo`.
- R10: Vectors 0, 1, 3, 4, 5, 6, 7, 9 and 16 clear `outErrPush` and give `outErrCode` 0.
- R11: Cause codes 17 to 31 are taken and dropped with no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Event offered |
| inReady | output | 1 | Block can take an event |
| cause | input | 5 | Event cause code |
| curAddr | input | 32 | Address of the instruction that raised the event |
| nextAddr | input | 32 | Address of the next sequential instruction |
| branchTaken | input | 1 | The instruction redirected program flow |
| branchTarget | input | 32 | Redirect target |
| ofFlag | input | 1 | Overflow status bit |
| emFlag | input | 1 | Coprocessor emulate bit |
| mpFlag | input | 1 | Monitor coprocessor bit |
| tsFlag | input | 1 | Task switched bit |
| errInfo | input | 32 | Selector or fault detail for the error code |
| outValid | output | 1 | Result available |
| outReady | input | 1 | Consumer takes the result |
| outVec | output | 8 | Vector number |
| outClass | output | 2 | 0 fault, 1 trap, 2 abort |
| outRetAddr | output | 32 | Return address to save |
| outErrPush | output | 1 | An error code is pushed |
| outErrCode | output | 32 | Error code value |

## Verification
The assertions check the following on every cycle:
- the ready/valid coupling;
- that a result stays stable under backpressure;
- the fault return-address rule;
- the zero return address of aborts;
- the always-zero error code of vector 8;
- the error-code rule of vector 6.

Only the bench scenarios can show which events are dropped by the status-bit conditions and the undefined codes. The same holds for the full cause-to-vector table and for the trap choice between the branch target and the next address. The bench checks these against its cycle model across directed and random traffic.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CAUSE_W = 5;
  localparam int VEC_W   = 8;

  typedef enum logic [1:0] {
    CLS_FAULT = 2'd0,
    CLS_TRAP  = 2'd1,
    CLS_ABORT = 2'd2
  } excClass_e;

  typedef enum logic [CAUSE_W-1:0] {
    C_DIVZERO  = 5'd0,
    C_DBGFAULT = 5'd1,
    C_DBGTRAP  = 5'd2,
    C_BRKPT    = 5'd3,
    C_OVFCHK   = 5'd4,
    C_BOUNDS   = 5'd5,
    C_BADOP    = 5'd6,
    C_ESCOP    = 5'd7,
    C_WAITOP   = 5'd8,
    C_DOUBLE   = 5'd9,
    C_CPSEG    = 5'd10,
    C_BADTSS   = 5'd11,
    C_NOTPRES  = 5'd12,
    C_STACK    = 5'd13,
    C_GPROT    = 5'd14,
    C_PAGE     = 5'd15,
    C_CPERR    = 5'd16
  } excCause_e;

  typedef struct packed {
    logic [VEC_W-1:0] vec;
    excClass_e        cls;
    logic             errPush;
    logic             errZero;
    logic             live;
  } decodeOut_t;

  typedef struct packed {
    logic load;
    logic clear;
  } ctrlStrobe_t;
endpackage

// File: rtl/exc_decode.sv
module exc_decode
  import exc_pkg::*;
(
  input  logic [CAUSE_W-1:0] cause,
  input  logic               ofFlag,
  input  logic               emFlag,
  input  logic               mpFlag,
  input  logic               tsFlag,
  output decodeOut_t         dec
);
  logic cpBusy;
  assign cpBusy = mpFlag & tsFlag;

  always_comb begin
    dec.vec     = '0;
    dec.cls     = CLS_FAULT;
    dec.errPush = 1'b0;
    dec.errZero = 1'b0;
    dec.live    = 1'b1;
    case (cause)
      C_DIVZERO:  dec.vec = 8'd0;
      C_DBGFAULT: dec.vec = 8'd1;
      C_DBGTRAP:  begin dec.vec = 8'd1; dec.cls = CLS_TRAP; end
      C_BRKPT:    begin dec.vec = 8'd3; dec.cls = CLS_TRAP; end
      C_OVFCHK:   begin dec.vec = 8'd4; dec.cls = CLS_TRAP; dec.live = ofFlag; end
      C_BOUNDS:   dec.vec = 8'd5;
      C_BADOP:    dec.vec = 8'd6;
      C_ESCOP:    begin dec.vec = 8'd7; dec.live = emFlag | cpBusy; end
      C_WAITOP:   begin dec.vec = 8'd7; dec.live = cpBusy; end
      C_DOUBLE:   begin dec.vec = 8'd8; dec.cls = CLS_ABORT;
                        dec.errPush = 1'b1; dec.errZero = 1'b1; end
      C_CPSEG:    begin dec.vec = 8'd9; dec.cls = CLS_ABORT; end
      C_BADTSS:   begin dec.vec = 8'd10; dec.errPush = 1'b1; end
      C_NOTPRES:  begin dec.vec = 8'd11; dec.errPush = 1'b1; end
      C_STACK:    begin dec.vec = 8'd12; dec.errPush = 1'b1; end
      C_GPROT:    begin dec.vec = 8'd13; dec.errPush = 1'b1; end
      C_PAGE:     begin dec.vec = 8'd14; dec.errPush = 1'b1; end
      C_CPERR:    dec.vec = 8'd16;
      default:    dec.live = 1'b0;
    endcase
  end
endmodule

// File: rtl/exc_control.sv
module exc_control
  import exc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        eventLive,
  input  logic        outReady,
  output ctrlStrobe_t strobe,
  output logic        outValid,
  output logic        inReady
);
  logic validQ;

  assign inReady      = ~validQ;
  assign strobe.load  = inValid & ~validQ & eventLive;
  assign strobe.clear = validQ & outReady;
  assign outValid     = validQ;

  always_ff @(posedge clk) begin
    if (!rstN)             validQ <= 1'b0;
    else if (strobe.load)  validQ <= 1'b1;
    else if (strobe.clear) validQ <= 1'b0;
  end
endmodule

// File: rtl/exc_datapath.sv
module exc_datapath
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ERR_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  decodeOut_t        dec,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [ADDR_W-1:0] nextAddr,
  input  logic              branchTaken,
  input  logic [ADDR_W-1:0] branchTarget,
  input  logic [ERR_W-1:0]  errInfo,
  output logic [VEC_W-1:0]  outVec,
  output logic [1:0]        outClass,
  output logic [ADDR_W-1:0] outRetAddr,
  output logic              outErrPush,
  output logic [ERR_W-1:0]  outErrCode
);
  logic [ADDR_W-1:0] retSel;
  logic [ERR_W-1:0]  errSel;

  always_comb begin
    case (dec.cls)
      CLS_FAULT: retSel = curAddr;
      CLS_TRAP:  retSel = branchTaken ? branchTarget : nextAddr;
      default:   retSel = '0;
    endcase
    errSel = (dec.errPush && !dec.errZero) ? errInfo : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outVec     <= '0;
      outClass   <= 2'd0;
      outRetAddr <= '0;
      outErrPush <= 1'b0;
      outErrCode <= '0;
    end else if (strobe.load) begin
      outVec     <= dec.vec;
      outClass   <= dec.cls;
      outRetAddr <= retSel;
      outErrPush <= dec.errPush;
      outErrCode <= errSel;
    end
  end
endmodule

// File: rtl/exc_classifier.sv
module exc_classifier
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ERR_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [ADDR_W-1:0]  curAddr,
  input  logic [ADDR_W-1:0]  nextAddr,
  input  logic               branchTaken,
  input  logic [ADDR_W-1:0]  branchTarget,
  input  logic               ofFlag,
  input  logic               emFlag,
  input  logic               mpFlag,
  input  logic               tsFlag,
  input  logic [ERR_W-1:0]   errInfo,
  output logic               outValid,
  input  logic               outReady,
  output logic [VEC_W-1:0]   outVec,
  output logic [1:0]         outClass,
  output logic [ADDR_W-1:0]  outRetAddr,
  output logic               outErrPush,
  output logic [ERR_W-1:0]   outErrCode
);
  decodeOut_t  dec;
  ctrlStrobe_t strobe;

  exc_decode u_decode (
    .cause(cause), .ofFlag(ofFlag), .emFlag(emFlag),
    .mpFlag(mpFlag), .tsFlag(tsFlag), .dec(dec)
  );

  exc_control u_control (
    .clk(clk), .rstN(rstN), .inValid(inValid), .eventLive(dec.live),
    .outReady(outReady), .strobe(strobe), .outValid(outValid), .inReady(inReady)
  );

  exc_datapath #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dec(dec),
    .curAddr(curAddr), .nextAddr(nextAddr), .branchTaken(branchTaken),
    .branchTarget(branchTarget), .errInfo(errInfo),
    .outVec(outVec), .outClass(outClass), .outRetAddr(outRetAddr),
    .outErrPush(outErrPush), .outErrCode(outErrCode)
  );
endmodule

// File: rtl/exc_classifier_chk.sv
module exc_classifier_chk #(
  parameter int ADDR_W = 32,
  parameter int ERR_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inReady,
  input logic [ADDR_W-1:0] curAddr,
  input logic              outValid,
  input logic              outReady,
  input logic [7:0]        outVec,
  input logic [1:0]        outClass,
  input logic [ADDR_W-1:0] outRetAddr,
  input logic              outErrPush,
  input logic [ERR_W-1:0]  outErrCode
);
  assert_ready_free_R2: assert property (@(posedge clk) disable iff (!rstN)
    inReady == !outValid);

  assert_hold_stall_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outVec) && $stable(outClass)
      && $stable(outRetAddr) && $stable(outErrPush) && $stable(outErrCode)));

  assert_fault_ret_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(outValid) && outClass == 2'd0) |-> outRetAddr == $past(curAddr));

  assert_abort_ret_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outClass == 2'd2) |-> outRetAddr == '0);

  assert_dbl_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outVec == 8'd8) |-> (outErrPush && outErrCode == '0));

  assert_badop_noerr_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outVec == 8'd6) |-> !outErrPush);
endmodule

bind exc_classifier exc_classifier_chk #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .curAddr(curAddr),
  .outValid(outValid), .outReady(outReady), .outVec(outVec),
  .outClass(outClass), .outRetAddr(outRetAddr), .outErrPush(outErrPush),
  .outErrCode(outErrCode)
);

// File: tb/tb_exc_classifier.sv
module tb_exc_classifier;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic inValid = 0, inReady, branchTaken = 0, ofFlag = 0, emFlag = 0, mpFlag = 0, tsFlag = 0;
  logic [4:0] cause = '0;
  logic [31:0] curAddr = '0, nextAddr = '0, branchTarget = '0, errInfo = '0;
  logic outValid, outReady = 0, outErrPush;
  logic [7:0] outVec;
  logic [1:0] outClass;
  logic [31:0] outRetAddr, outErrCode;

  exc_classifier dut (.*);

  int nChecks = 0, nFails = 0;
  bit mValid = 0;
  int mVec, mCls, mErrPush;
  logic [31:0] mRet, mErr;
  bit done = 0;

  task automatic chk(string tag, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Behavioural expectation: returns live; fills vector/class/err fields
  function automatic bit expect_ev(int c, output int v, output int cl, output int ep,
                                   output logic [31:0] ec);
    bit lv = 1;
    cl = 0; ep = 0; ec = 0; v = 0;
    if (c == 0) v = 0;
    else if (c == 1) v = 1;
    else if (c == 2) begin v = 1; cl = 1; end
    else if (c == 3) begin v = 3; cl = 1; end
    else if (c == 4) begin v = 4; cl = 1; lv = ofFlag; end
    else if (c == 5) v = 5;
    else if (c == 6) v = 6;
    else if (c == 7) begin v = 7; lv = emFlag || (mpFlag && tsFlag); end
    else if (c == 8) begin v = 7; lv = mpFlag && tsFlag; end
    else if (c == 9) begin v = 8; cl = 2; ep = 1; end
    else if (c == 10) begin v = 9; cl = 2; end
    else if (c >= 11 && c <= 15) begin v = c - 1; ep = 1; ec = errInfo; end
    else if (c == 16) v = 16;
    else lv = 0;
    return lv;
  endfunction

  // Compare outputs against the model, then advance the model for the next edge
  task automatic cycle();
    int v, cl, ep;
    logic [31:0] ec;
    chk("R2 inReady", inReady, !mValid);
    chk("R2 outValid", outValid, mValid);
    if (mValid && outValid) begin
      chk("R6 vector", outVec, mVec);
      chk("R6 class", outClass, mCls);
      if (mCls == 0) chk("R3 fault ret", outRetAddr, mRet);
      else if (mCls == 1) chk("R4 trap ret", outRetAddr, mRet);
      else chk("R5 abort ret", outRetAddr, mRet);
      if (mErrPush) begin
        chk("R9 errPush", outErrPush, 1);
        chk("R9 errCode", outErrCode, mErr);
      end else begin
        chk("R10 errPush", outErrPush, 0);
        chk("R10 errCode", outErrCode, 0);
      end
    end
    if (mValid && outReady) mValid = 0;
    else if (!mValid && inValid && expect_ev(int'(cause), v, cl, ep, ec)) begin
      mValid = 1; mVec = v; mCls = cl; mErrPush = ep; mErr = ec;
      mRet = (cl == 0) ? curAddr : (cl == 1) ? (branchTaken ? branchTarget : nextAddr) : 32'd0;
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic offer(int c, bit tk, bit rdy);
    inValid = 1; cause = 5'(c); branchTaken = tk;
    curAddr = $urandom; nextAddr = $urandom; branchTarget = $urandom; errInfo = $urandom;
    outReady = rdy;
    cycle();
    inValid = 0;
  endtask

  task automatic drain();
    outReady = 1; cycle(); cycle(); outReady = 0;
  endtask

  task automatic dropped(string tag, int c);
    drain();
    offer(c, 0, 0);
    chk(tag, outValid, 0);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1;
    chk("R1 reset outValid", outValid, 0);
    chk("R1 reset inReady", inReady, 1);
    // every cause, both branch choices, with backpressure
    for (int c = 0; c < 17; c++) begin
      ofFlag = 1; emFlag = 1; mpFlag = 1; tsFlag = 1;
      offer(c, c[0], 0);
      cycle(); cycle();
      drain();
    end
    ofFlag = 0; dropped("R7 overflow dropped", 4);
    ofFlag = 1; offer(4, 1, 1); chk("R7 overflow raised", outValid, 1); drain();
    emFlag = 0; mpFlag = 1; tsFlag = 0; dropped("R8 esc dropped", 7);
    mpFlag = 0; tsFlag = 1; dropped("R8 wait dropped", 8);
    emFlag = 1; mpFlag = 0; offer(7, 0, 0); chk("R8 esc emulate", outValid, 1); drain();
    emFlag = 1; dropped("R8 wait ignores em", 8);
    for (int c = 17; c < 32; c++) dropped("R11 undefined", c);
    offer(3, 1, 0); chk("R4 taken trap", outRetAddr, branchTarget); drain();
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      ofFlag = $urandom; emFlag = $urandom; mpFlag = $urandom; tsFlag = $urandom;
      inValid = $urandom; cause = 5'($urandom);
      branchTaken = $urandom; curAddr = $urandom; nextAddr = $urandom;
      branchTarget = $urandom; errInfo = $urandom; outReady = $urandom;
      cycle();
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); nChecks++; nFails++;
        $display("FAIL watchdog act=running exp=done"); end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule